// File: doc/BRIEF.md
# Two-Phase Stack Machine Execution Core

This block is the execution core of a 16-bit stack machine without microcode. Every clock it accepts one 8-bit control word. Each field of that word drives one part of the datapath directly. The core holds two 8-bit stack pointers, one for data and one for return addresses, and a 16-bit top-of-stack register (TOS). It also holds a 256-word stack memory, a program counter that addresses an external ROM, and an ALU with two functions, ADD and NAND. A RAM port takes its 15-bit address from TOS.

TOS captures the value on its source bus only at the end of every second cycle. A full instruction is therefore a pair of control words. The first word of a pair usually moves a pointer and a stack word. The second word commits the new TOS and may take a jump. For example, a literal push is made of two words:

- Cycle one: the data pointer counts up, the old TOS is written to the stack, and the ROM word is on the TOS bus.
- Cycle two: the ROM word is still on the TOS bus, and TOS captures it.

A sequencer or a program store outside the block supplies the control words.

Top module: `stkm_core`

## Requirements
- R1: While reset is asserted, and right after it is released, TOS, both stack pointers, the program counter and the phase bit are all zero.
- R2: Control bit 5 high makes one pointer count. Bit 7 low picks the data pointer and bit 7 high picks the return pointer. Bit 6 high counts up and bit 6 low counts down. The count wraps modulo 256, and the pointer that is not picked keeps its value.
- R3: With bit 5 low, neither pointer changes, whatever the value of bit 6.
- R4: Bit 4 is active low. When bit 4 is high, TOS is removed from the ALU operand, from the RAM address and from the stack bus. Each of these then reads zero.
- R5: The stack-bus field is bits 3:2. Code 00 puts the stack word at the picked pointer onto the stack bus as the second ALU operand. Code 01 writes the TOS operand into that stack word.
- R6: Stack-bus code 10 drives that stack word onto the RAM write data and asserts the RAM write strobe. Code 11 writes the RAM read data into that stack word. The write strobe is low for every other code.
- R7: The TOS-bus field is bits 1:0. Code 00 selects the ROM word. Code 01 selects NAND of the TOS operand and the stack bus. Code 10 selects their 16-bit sum, with the carry dropped. Code 11 keeps the current TOS.
- R8: The phase bit toggles every cycle. TOS loads the TOS-bus value only at the end of a cycle in which the phase bit is 1.
- R9: In a phase-1 cycle with TOS-bus code 11 and TOS equal to zero, the program counter loads the current ROM word. In every other cycle it increments by one.
- R10: The RAM address is the low 15 bits of the TOS operand. A stack access always uses the picked pointer's value from before that cycle's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 8 | Control word for this cycle |
| rom_data_i | input | 16 | ROM word at `pc_o` (literal or jump target) |
| ram_rdata_i | input | 16 | RAM read data |
| pc_o | output | 16 | Program counter, ROM address |
| ram_addr_o | output | 15 | RAM address taken from TOS |
| ram_wdata_o | output | 16 | RAM write data (stack bus) |
| ram_we_o | output | 1 | RAM write strobe |
| tos_o | output | 16 | Top-of-stack register |
| dsp_o | output | 8 | Data stack pointer |
| rsp_o | output | 8 | Return stack pointer |
| phase_o | output | 1 | Phase bit, 1 in the cycle that commits TOS |

## Verification
A wrong pointer shows on `dsp_o` or `rsp_o` at the edge where it goes wrong. A wrong stack memory word stays hidden until a later control word reads that location. It then shows on `ram_wdata_o` in the same cycle, or in TOS after the next commit edge. A phase bit that slips shows as TOS loading on the wrong edge, so `tos_o` differs within two cycles. A wrong jump decision appears on `pc_o` at the following edge. For these reasons the reference model compares every port on every cycle, and directed sequences write known words to the stack and read them back through the ALU.

// File: rtl/stkm_pkg.sv
package stkm_pkg;

    localparam int OP_W = 8;

    typedef enum logic [1:0] {
        SB_OPERAND   = 2'b00,
        SB_TOS_PUSH  = 2'b01,
        SB_STK_2_RAM = 2'b10,
        SB_RAM_2_STK = 2'b11
    } sbus_op_e;

    typedef enum logic [1:0] {
        TB_ROM  = 2'b00,
        TB_NAND = 2'b01,
        TB_ADD  = 2'b10,
        TB_JZ   = 2'b11
    } tbus_op_e;

    typedef struct packed {
        logic     rsel;
        logic     up;
        logic     cnt_en;
        logic     tos_off;
        sbus_op_e sb;
        tbus_op_e tb;
    } ctrl_word_t;

endpackage

// File: rtl/stkm_ptr_unit.sv
module stkm_ptr_unit #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsel_i,
    input  logic             up_i,
    input  logic             cnt_en_i,
    output logic [PTR_W-1:0] dsp_o,
    output logic [PTR_W-1:0] rsp_o,
    output logic [PTR_W-1:0] cur_o
);

    localparam int NPTR = 2;

    logic [PTR_W-1:0] ptr_d [NPTR];
    logic [PTR_W-1:0] ptr_q [NPTR];

    always_comb begin
        for (int i = 0; i < NPTR; i++) begin
            ptr_d[i] = ptr_q[i];
            if (cnt_en_i && (int'(rsel_i) == i)) begin
                ptr_d[i] = up_i ? ptr_q[i] + 1'b1 : ptr_q[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTR; i++) begin
                ptr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NPTR; i++) begin
                ptr_q[i] <= ptr_d[i];
            end
        end
    end

    assign dsp_o = ptr_q[0];
    assign rsp_o = ptr_q[1];
    assign cur_o = rsel_i ? ptr_q[1] : ptr_q[0];

endmodule

// File: rtl/stkm_stack_mem.sv
module stkm_stack_mem #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/stkm_alu.sv
module stkm_alu
    import stkm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  tbus_op_e          sel_i,
    input  logic [DATA_W-1:0] opnd_a_i,
    input  logic [DATA_W-1:0] opnd_b_i,
    input  logic [DATA_W-1:0] rom_i,
    input  logic [DATA_W-1:0] tos_i,
    output logic [DATA_W-1:0] tbus_o
);

    always_comb begin
        unique case (sel_i)
            TB_ROM:  tbus_o = rom_i;
            TB_NAND: tbus_o = ~(opnd_a_i & opnd_b_i);
            TB_ADD:  tbus_o = opnd_a_i + opnd_b_i;
            default: tbus_o = tos_i;
        endcase
    end

endmodule

// File: rtl/stkm_core.sv
module stkm_core
    import stkm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 8,
    parameter int PC_W   = 16,
    parameter int RAM_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] rom_data_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              ram_we_o,
    output logic [DATA_W-1:0] tos_o,
    output logic [PTR_W-1:0]  dsp_o,
    output logic [PTR_W-1:0]  rsp_o,
    output logic              phase_o
);

    typedef struct packed {
        logic [DATA_W-1:0] tos;
        logic [PC_W-1:0]   pc;
        logic              phase;
    } core_state_t;

    core_state_t state_d, state_q;
    ctrl_word_t  ctrl;

    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] sbus;
    logic [DATA_W-1:0] stk_rdata;
    logic [DATA_W-1:0] tbus;
    logic [PTR_W-1:0]  stk_addr;
    logic              stk_we;
    logic              ram_we;
    logic              jump_take;

    assign ctrl = ctrl_word_t'(op_i);

    // Operand gate: a disabled TOS reads as zero everywhere it would drive
    assign opnd_a = ctrl.tos_off ? '0 : state_q.tos;

    // Stack-bus transfer decode
    always_comb begin
        sbus   = stk_rdata;
        stk_we = 1'b0;
        ram_we = 1'b0;
        unique case (ctrl.sb)
            SB_OPERAND:   sbus = stk_rdata;
            SB_TOS_PUSH: begin
                sbus   = opnd_a;
                stk_we = 1'b1;
            end
            SB_STK_2_RAM: begin
                sbus   = stk_rdata;
                ram_we = 1'b1;
            end
            default: begin
                sbus   = ram_rdata_i;
                stk_we = 1'b1;
            end
        endcase
    end

    stkm_ptr_unit #(
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rsel_i   (ctrl.rsel),
        .up_i     (ctrl.up),
        .cnt_en_i (ctrl.cnt_en),
        .dsp_o    (dsp_o),
        .rsp_o    (rsp_o),
        .cur_o    (stk_addr)
    );

    stkm_stack_mem #(
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W)
    ) u_stk (
        .clk     (clk),
        .we_i    (stk_we),
        .addr_i  (stk_addr),
        .wdata_i (sbus),
        .rdata_o (stk_rdata)
    );

    stkm_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .sel_i    (ctrl.tb),
        .opnd_a_i (opnd_a),
        .opnd_b_i (sbus),
        .rom_i    (rom_data_i),
        .tos_i    (state_q.tos),
        .tbus_o   (tbus)
    );

    assign jump_take = state_q.phase && (ctrl.tb == TB_JZ) && (state_q.tos == '0);

    always_comb begin
        state_d       = state_q;
        state_d.phase = ~state_q.phase;
        if (state_q.phase) begin
            state_d.tos = tbus;
        end
        if (jump_take) begin
            state_d.pc = PC_W'(rom_data_i);
        end else begin
            state_d.pc = state_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o        = state_q.pc;
    assign tos_o       = state_q.tos;
    assign phase_o     = state_q.phase;
    assign ram_addr_o  = opnd_a[RAM_AW-1:0];
    assign ram_wdata_o = sbus;
    assign ram_we_o    = ram_we;

endmodule

// File: rtl/stkm_core_chk.sv
module stkm_core_chk #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 8,
    parameter int PC_W   = 16,
    parameter int RAM_AW = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        op_i,
    input logic [DATA_W-1:0] rom_data_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [RAM_AW-1:0] ram_addr_o,
    input logic              ram_we_o,
    input logic [DATA_W-1:0] tos_o,
    input logic [PTR_W-1:0]  dsp_o,
    input logic [PTR_W-1:0]  rsp_o,
    input logic              phase_o
);

    a_r8_tos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_o |=> $stable(tos_o));

    a_r8_phase_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_o |=> phase_o);

    a_r8_phase_fall: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o |=> !phase_o);

    a_r3_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        !op_i[5] |=> ($stable(dsp_o) && $stable(rsp_o)));

    a_r2_keep_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !op_i[7] |=> $stable(rsp_o));

    a_r2_keep_dsp: assert property (@(posedge clk) disable iff (!rst_n)
        op_i[7] |=> $stable(dsp_o));

    a_r2_dsp_up: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[5] && op_i[6] && !op_i[7]) |=> (dsp_o == PTR_W'($past(dsp_o) + 1'b1)));

    a_r4_addr_off: assert property (@(posedge clk) disable iff (!rst_n)
        op_i[4] |-> (ram_addr_o == '0));

    a_r6_we_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[3:2] != 2'b10) |-> !ram_we_o);

    a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_o && (op_i[1:0] == 2'b11)) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

    a_r9_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o && (op_i[1:0] == 2'b11) && (tos_o == '0)) |=> (pc_o == PC_W'($past(rom_data_i))));

endmodule

bind stkm_core stkm_core_chk #(
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W),
    .PC_W   (PC_W),
    .RAM_AW (RAM_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .rom_data_i (rom_data_i),
    .pc_o       (pc_o),
    .ram_addr_o (ram_addr_o),
    .ram_we_o   (ram_we_o),
    .tos_o      (tos_o),
    .dsp_o      (dsp_o),
    .rsp_o      (rsp_o),
    .phase_o    (phase_o)
);

// File: tb/stkm_core_tb.sv
module stkm_core_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  op_i;
    logic [15:0] rom_data_i;
    logic [15:0] ram_rdata_i;
    logic [15:0] pc_o;
    logic [14:0] ram_addr_o;
    logic [15:0] ram_wdata_o;
    logic        ram_we_o;
    logic [15:0] tos_o;
    logic [7:0]  dsp_o;
    logic [7:0]  rsp_o;
    logic        phase_o;

    always #4 clk = ~clk;

    stkm_core u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_i),
        .rom_data_i  (rom_data_i),
        .ram_rdata_i (ram_rdata_i),
        .pc_o        (pc_o),
        .ram_addr_o  (ram_addr_o),
        .ram_wdata_o (ram_wdata_o),
        .ram_we_o    (ram_we_o),
        .tos_o       (tos_o),
        .dsp_o       (dsp_o),
        .rsp_o       (rsp_o),
        .phase_o     (phase_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [15:0] m_tos, m_pc;
    logic [7:0]  m_dsp, m_rsp;
    logic        m_ph;
    logic [15:0] m_stk [256];
    // Planned next values
    logic [15:0] n_tos, n_pc, n_wval;
    logic [7:0]  n_dsp, n_rsp, n_widx;
    logic        n_wr;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [7:0] op, logic [15:0] rom, logic [15:0] ram);
        logic [15:0] a, rd, sb, tv;
        logic [7:0]  sp;
        logic        we;
        op_i        = op;
        rom_data_i  = rom;
        ram_rdata_i = ram;
        a  = op[4] ? 16'h0 : m_tos;
        sp = op[7] ? m_rsp : m_dsp;
        rd = m_stk[sp];
        we = 1'b0;
        n_wr = 1'b0;
        sb = rd;
        case (op[3:2])
            2'd0: sb = rd;
            2'd1: begin sb = a; n_wr = 1'b1; end
            2'd2: begin sb = rd; we = 1'b1; end
            default: begin sb = ram; n_wr = 1'b1; end
        endcase
        case (op[1:0])
            2'd0: tv = rom;
            2'd1: tv = ~(a & sb);
            2'd2: tv = a + sb;
            default: tv = m_tos;
        endcase
        n_widx = sp;
        n_wval = sb;
        n_tos  = m_ph ? tv : m_tos;
        n_pc   = (m_ph && op[1:0] == 2'd3 && m_tos == 16'h0) ? rom : m_pc + 16'd1;
        n_dsp  = m_dsp;
        n_rsp  = m_rsp;
        if (op[5]) begin
            if (op[7]) n_rsp = op[6] ? m_rsp + 8'd1 : m_rsp - 8'd1;
            else       n_dsp = op[6] ? m_dsp + 8'd1 : m_dsp - 8'd1;
        end
        #1;
        chk("R8 tos", 32'(tos_o), 32'(m_tos));
        chk("R8 phase", 32'(phase_o), 32'(m_ph));
        chk("R2 dsp", 32'(dsp_o), 32'(m_dsp));
        chk("R2 rsp", 32'(rsp_o), 32'(m_rsp));
        chk("R9 pc", 32'(pc_o), 32'(m_pc));
        chk("R10 ram_addr", 32'(ram_addr_o), 32'(a[14:0]));
        chk("R6 ram_we", 32'(ram_we_o), 32'(we));
        chk("R5 ram_wdata", 32'(ram_wdata_o), 32'(sb));
    endtask

    task automatic adv();
        @(posedge clk);
        m_tos = n_tos;
        m_pc  = n_pc;
        m_dsp = n_dsp;
        m_rsp = n_rsp;
        m_ph  = ~m_ph;
        if (n_wr) m_stk[n_widx] = n_wval;
        @(negedge clk);
    endtask

    task automatic step(logic [7:0] op, logic [15:0] rom, logic [15:0] ram);
        drive(op, rom, ram);
        adv();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] pc_before;
        rst_n = 1'b0;
        op_i = 8'h0; rom_data_i = 16'h0; ram_rdata_i = 16'h0;
        m_tos = 0; m_pc = 0; m_dsp = 0; m_rsp = 0; m_ph = 0;
        for (int i = 0; i < 256; i++) m_stk[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 tos", 32'(tos_o), 0);
        chk("R1 dsp", 32'(dsp_o), 0);
        chk("R1 rsp", 32'(rsp_o), 0);
        chk("R1 pc", 32'(pc_o), 0);
        chk("R1 phase", 32'(phase_o), 0);
        rst_n = 1'b1;

        // Fill the whole stack with zero through both pointers; each wraps (R2)
        for (int i = 0; i < 256; i++) step(8'h67, 16'h0, 16'h0);
        chk("R2 dsp wrap", 32'(dsp_o), 0);
        for (int i = 0; i < 256; i++) step(8'hE7, 16'h0, 16'h0);
        chk("R2 rsp wrap", 32'(rsp_o), 0);

        // Push literal: TOS loads only on the second edge (R8, R7)
        step(8'h64, 16'h1234, 16'h0);
        chk("R8 tos held after phase-0 cycle", 32'(tos_o), 0);
        step(8'h00, 16'h1234, 16'h0);
        chk("R7 literal loaded", 32'(tos_o), 32'h1234);
        chk("R2 dsp after push", 32'(dsp_o), 1);

        // R5: TOS into stack[1], clear TOS, read back through ADD with TOS off
        step(8'h07, 16'h0, 16'h0);
        step(8'h03, 16'h0, 16'h0);
        step(8'h00, 16'h0, 16'h0);
        step(8'h00, 16'h0, 16'h0);
        step(8'h12, 16'h0, 16'h0);
        step(8'h12, 16'h0, 16'h0);
        chk("R5 stack readback", 32'(tos_o), 32'h1234);

        // R6: RAM word into stack[1], read back, then stack to RAM
        step(8'h0F, 16'h0, 16'hBEEF);
        step(8'h03, 16'h0, 16'h0);
        step(8'h12, 16'h0, 16'h0);
        step(8'h12, 16'h0, 16'h0);
        chk("R6 ram to stack", 32'(tos_o), 32'hBEEF);
        drive(8'h0B, 16'h0, 16'h0);
        chk("R6 write strobe", 32'(ram_we_o), 1);
        chk("R6 write data", 32'(ram_wdata_o), 32'hBEEF);
        chk("R10 address bit 15 dropped", 32'(ram_addr_o), 32'h3EEF);
        adv();
        drive(8'h1B, 16'h0, 16'h0);
        chk("R4 address gated", 32'(ram_addr_o), 0);
        adv();

        // R2 down count with wrap, R3 no count while bit 5 is low
        step(8'h23, 16'h0, 16'h0);
        step(8'h23, 16'h0, 16'h0);
        chk("R2 dsp down wrap", 32'(dsp_o), 32'hFF);
        step(8'h43, 16'h0, 16'h0);
        step(8'h43, 16'h0, 16'h0);
        chk("R3 dsp unchanged", 32'(dsp_o), 32'hFF);
        chk("R2 rsp untouched", 32'(rsp_o), 0);

        // R9: jump not taken with TOS nonzero, then taken with TOS zero
        pc_before = pc_o;
        step(8'h03, 16'h0055, 16'h0);
        step(8'h03, 16'h0055, 16'h0);
        chk("R9 not taken", 32'(pc_o), 32'(pc_before + 16'd2));
        step(8'h00, 16'h0, 16'h0);
        step(8'h00, 16'h0, 16'h0);
        step(8'h03, 16'h00AA, 16'h0);
        step(8'h03, 16'h00AA, 16'h0);
        chk("R9 taken", 32'(pc_o), 32'h00AA);

        // R7: NAND and ADD against stack[255]
        step(8'h00, 16'h0F0F, 16'h0);
        step(8'h00, 16'h0F0F, 16'h0);
        step(8'h07, 16'h0, 16'h0);
        step(8'h03, 16'h0, 16'h0);
        step(8'h00, 16'h00FF, 16'h0);
        step(8'h00, 16'h00FF, 16'h0);
        step(8'h01, 16'h0, 16'h0);
        step(8'h01, 16'h0, 16'h0);
        chk("R7 nand", 32'(tos_o), 32'hFFF0);
        step(8'h02, 16'h0, 16'h0);
        step(8'h02, 16'h0, 16'h0);
        chk("R7 add carry dropped", 32'(tos_o), 32'h0EFF);

        // Mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            step(8'($urandom), 16'($urandom), 16'($urandom));
        end

        done = 1'b1;
        finish_run();
    end

endmodule